// File: doc/BRIEF.md
# Iterative 256-bit Hash Compression Engine

This block runs the 64-round compression step of a 256-bit iterative hash over one 512-bit message block. It keeps eight 32-bit working words and performs one round per clock. A companion expansion unit, outside this block, supplies the two per-round message words: the plain word W and the mixed word W'. When the last round has been applied, the engine folds the chaining value it captured at the start into the working words and presents the result as the new chaining value.

A host starts the engine with a one-cycle `start` pulse, with the current chaining value on `chain_in`. The engine raises `word_ready` for the whole round phase. A round advances only in a cycle where `word_valid` is also high, so the expansion unit can stall the engine at any point. Padding, length encoding and the sequencing of several blocks stay with the host. To chain blocks, the host feeds `chain_out` back into `chain_in`.

The controller has three named states:
- `PH_IDLE` waits for a start pulse.
- `PH_ROUND` consumes round words.
- `PH_MERGE` folds the captured chaining value into the result.

It has four transitions:
- `PH_IDLE`→`PH_ROUND` on `start`.
- `PH_ROUND`→`PH_ROUND` while rounds remain or the engine is stalled.
- `PH_ROUND`→`PH_MERGE` when the word for round 63 is accepted.
- `PH_MERGE`→`PH_IDLE` unconditionally.

Top module: `hce_engine`

## Requirements
- R1: While reset is held, and right after it is released, `done` and `word_ready` are 0 and `chain_out` is all zeros.
- R2: A `start` pulse in `PH_IDLE` captures `chain_in` and moves the engine to `PH_ROUND` with round index 0. `word_ready` is high from the next cycle, and later changes on `chain_in` have no effect. Words are packed with word a in bits 255:224 down to word h in bits 31:0.
- R3: A round is applied only in a cycle where both `word_valid` and `word_ready` are high. Otherwise the working words and round index are held. Exactly 64 accepted word pairs complete a block, and `done` stays low until then.
- R4: Each round forms SS1 = ((a rotl 12) + e + Tj) rotl 7 and SS2 = SS1 xor (a rotl 12), with all sums modulo 2^32. Tj is 0x79CC4519 for rounds 0–15 and 0x7A879D8A for rounds 16–63, rotated left by (j mod 32).
- R5: For rounds 0–15, both boolean functions are the three-input XOR. From round 16 on, FF is the bitwise majority of a, b and c, and GG is ((f xor g) and e) xor g.
- R6: TT1 = FF + d + SS2 + W'j and TT2 = GG + h + SS1 + Wj. The new words are:
  - a = TT1, b = a, c = b rotl 9, d = c;
  - e = TT2 xor (TT2 rotl 9) xor (TT2 rotl 17), f = e, g = f rotl 19, h = g.
- R7: Each output word is the final working word XOR-ed with the matching word of the chaining value captured at start.
- R8: The cycle after the last word is accepted is the merge cycle, with `done` still low. `done` is high for exactly the following cycle. `chain_out` changes only when `done` rises and holds its value until the next completion.
- R9: A `start` pulse while the engine is busy is ignored. The running block finishes with its original chaining value and its round count.
- R10: From the initial value 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E, the padded one-block message "abc" gives 66C7F0F4 62EEEDD9 D1F2D46B DC10E4E2 4167C487 5CF2F7A2 297DA02B 8F4BA8E0.
- R11: Feeding `chain_out` back as `chain_in` chains blocks. The two-block padded message of "abcd" repeated 16 times gives DEBE9FF9 2275B8A1 38604889 C18E5A4D 6FDB70E5 387E5765 293DCBA3 9C0C5732.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a block |
| chain_in | input | 256 | Chaining value, word a in the top bits |
| word_valid | input | 1 | Round word pair on `w_in`/`wp_in` is valid |
| w_in | input | 32 | Message word Wj for the current round |
| wp_in | input | 32 | Mixed message word W'j for the current round |
| word_ready | output | 1 | Engine will consume a word pair this cycle |
| done | output | 1 | One-cycle pulse: `chain_out` holds a new result |
| chain_out | output | 256 | Resulting chaining value |

## Verification
On every cycle, the bound checker watches the handshake and control behaviour:
- a start from idle restarts the round index at zero;
- the index steps by one on each accepted pair and holds during stalls;
- a start during a run is ignored;
- the last accepted word is followed by one quiet merge cycle and then a single-cycle `done`;
- `chain_out` moves only with `done`.

The arithmetic of the round cannot be judged cycle by cycle: the constants, the switch of boolean functions at round 16, the rotations, and the final XOR rather than an addition. Only the bench's scenarios can show these. They compare complete digests against the published one- and two-block vectors and against a model written from the requirements, with and without stalls and mid-run start pulses.

// File: rtl/hce_pkg.sv
package hce_pkg;

    localparam int WORD_W = 32;
    localparam int N_WORDS = 8;
    localparam int CV_W = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } cv_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ROUND = 2'd1,
        PH_MERGE = 2'd2
    } phase_t;

    function automatic word_t rotl32(input word_t x, input logic [4:0] n);
        return (x << n) | (x >> (6'd32 - {1'b0, n}));
    endfunction

    // permutation applied to the right-hand sum before it becomes word e
    function automatic word_t mix_e(input word_t x);
        return x ^ rotl32(x, 5'd9) ^ rotl32(x, 5'd17);
    endfunction

endpackage

// File: rtl/hce_fsm.sv
module hce_fsm
    import hce_pkg::*;
#(
    parameter int ROUNDS = 64,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_valid,
    output logic             word_ready,
    output logic             busy,
    output logic             load_en,
    output logic             step_en,
    output logic             merge_en,
    output logic [IDX_W-1:0] round_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

    phase_t           state_q;
    phase_t           state_d;
    logic [IDX_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d = PH_ROUND;
                end
            end
            PH_ROUND: begin
                if (word_valid && (cnt_q == LAST_IDX)) begin
                    state_d = PH_MERGE;
                end
            end
            PH_MERGE: begin
                state_d = PH_IDLE;
            end
            default: begin
                state_d = PH_IDLE;
            end
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        word_ready = 1'b0;
        busy       = 1'b1;
        load_en    = 1'b0;
        step_en    = 1'b0;
        merge_en   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                busy    = 1'b0;
                load_en = start;
            end
            PH_ROUND: begin
                word_ready = 1'b1;
                step_en    = word_valid;
            end
            PH_MERGE: begin
                merge_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // round counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= '0;
        end else if (step_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign round_idx = cnt_q;

endmodule

// File: rtl/hce_tgen.sv
module hce_tgen
    import hce_pkg::*;
#(
    parameter int    ROUNDS  = 64,
    parameter int    SPLIT   = 16,
    parameter word_t T_EARLY = 32'h79CC4519,
    parameter word_t T_LATE  = 32'h7A879D8A,
    localparam int   IDX_W   = $clog2(ROUNDS)
) (
    input  logic [IDX_W-1:0] round_idx,
    output word_t            t_rot,
    output logic             late
);

    localparam logic [IDX_W-1:0] SPLIT_IDX = IDX_W'(SPLIT);

    word_t base_t;

    always_comb begin
        late   = (round_idx >= SPLIT_IDX);
        base_t = late ? T_LATE : T_EARLY;
        // rotation amount is the round number modulo the word width
        t_rot  = rotl32(base_t, round_idx[4:0]);
    end

endmodule

// File: rtl/hce_round.sv
module hce_round
    import hce_pkg::*;
(
    input  cv_t   cur,
    input  word_t w_j,
    input  word_t wp_j,
    input  word_t t_j,
    input  logic  late,
    output cv_t   nxt
);

    word_t a_r12;
    word_t ss1;
    word_t ss2;
    word_t ff_v;
    word_t gg_v;
    word_t tt1;
    word_t tt2;

    always_comb begin
        a_r12 = rotl32(cur.a, 5'd12);
        ss1   = rotl32(a_r12 + cur.e + t_j, 5'd7);
        ss2   = ss1 ^ a_r12;

        if (late) begin
            ff_v = (cur.a & cur.b) | (cur.a & cur.c) | (cur.b & cur.c);
            gg_v = ((cur.f ^ cur.g) & cur.e) ^ cur.g;
        end else begin
            ff_v = cur.a ^ cur.b ^ cur.c;
            gg_v = cur.e ^ cur.f ^ cur.g;
        end

        tt1 = ff_v + cur.d + ss2 + wp_j;
        tt2 = gg_v + cur.h + ss1 + w_j;

        nxt.a = tt1;
        nxt.b = cur.a;
        nxt.c = rotl32(cur.b, 5'd9);
        nxt.d = cur.c;
        nxt.e = mix_e(tt2);
        nxt.f = cur.e;
        nxt.g = rotl32(cur.f, 5'd19);
        nxt.h = cur.g;
    end

endmodule

// File: rtl/hce_merge.sv
module hce_merge
    import hce_pkg::*;
#(
    parameter int  NW  = N_WORDS,
    localparam int VW  = NW * WORD_W
) (
    input  logic [VW-1:0] work,
    input  logic [VW-1:0] base,
    output logic [VW-1:0] result
);

    for (genvar i = 0; i < NW; i++) begin : g_word
        assign result[i*WORD_W +: WORD_W] = work[i*WORD_W +: WORD_W] ^ base[i*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/hce_engine.sv
module hce_engine
    import hce_pkg::*;
#(
    parameter int    ROUNDS  = 64,
    parameter int    SPLIT   = 16,
    parameter word_t T_EARLY = 32'h79CC4519,
    parameter word_t T_LATE  = 32'h7A879D8A,
    localparam int   IDX_W   = $clog2(ROUNDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CV_W-1:0] chain_in,
    input  logic            word_valid,
    input  logic [31:0]     w_in,
    input  logic [31:0]     wp_in,
    output logic            word_ready,
    output logic            done,
    output logic [CV_W-1:0] chain_out
);

    logic             busy;
    logic             load_en;
    logic             step_en;
    logic             merge_en;
    logic [IDX_W-1:0] round_idx;
    word_t            t_rot;
    logic             late;

    cv_t              work_q;
    cv_t              base_q;
    cv_t              work_nx;
    logic [CV_W-1:0]  merged;

    logic             done_q;
    logic [CV_W-1:0]  out_q;

    hce_fsm #(.ROUNDS(ROUNDS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .busy       (busy),
        .load_en    (load_en),
        .step_en    (step_en),
        .merge_en   (merge_en),
        .round_idx  (round_idx)
    );

    hce_tgen #(
        .ROUNDS  (ROUNDS),
        .SPLIT   (SPLIT),
        .T_EARLY (T_EARLY),
        .T_LATE  (T_LATE)
    ) u_tgen (
        .round_idx (round_idx),
        .t_rot     (t_rot),
        .late      (late)
    );

    hce_round u_round (
        .cur  (work_q),
        .w_j  (w_in),
        .wp_j (wp_in),
        .t_j  (t_rot),
        .late (late),
        .nxt  (work_nx)
    );

    hce_merge #(.NW(N_WORDS)) u_merge (
        .work   (work_q),
        .base   (base_q),
        .result (merged)
    );

    // working and captured chaining words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            base_q <= '0;
        end else if (load_en) begin
            work_q <= cv_t'(chain_in);
            base_q <= cv_t'(chain_in);
        end else if (step_en) begin
            work_q <= work_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            out_q  <= '0;
        end else begin
            done_q <= merge_en;
            if (merge_en) begin
                out_q <= merged;
            end
        end
    end

    assign done      = done_q;
    assign chain_out = out_q;

endmodule

// File: rtl/hce_checks.sv
module hce_checks #(
    parameter int  ROUNDS = 64,
    localparam int IDX_W  = $clog2(ROUNDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             word_valid,
    input logic             word_ready,
    input logic             done,
    input logic             busy,
    input logic [IDX_W-1:0] round_idx,
    input logic [255:0]     chain_out
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && word_ready && round_idx == '0)); // R2

    AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> busy); // R2

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && round_idx != LAST_IDX) |=> (word_ready && round_idx == $past(round_idx) + 1'b1)); // R3

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !word_valid) |=> (word_ready && $stable(round_idx))); // R3

    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && round_idx == LAST_IDX) |=> (!word_ready && !done) ##1 done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(chain_out)); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && word_ready && !word_valid && round_idx != '0) |=> (round_idx == $past(round_idx))); // R9

endmodule

bind hce_engine hce_checks #(.ROUNDS(ROUNDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .done       (done),
    .busy       (busy),
    .round_idx  (round_idx),
    .chain_out  (chain_out)
);

// File: tb/hce_engine_tb.sv
module hce_engine_tb;

    localparam logic [255:0] IV = 256'h7380166F4914B2B9172442D7DA8A0600A96F30BC163138AAE38DEE4DB0FB0E4E;
    localparam logic [255:0] ABC_DIGEST = 256'h66C7F0F462EEEDD9D1F2D46BDC10E4E24167C4875CF2F7A2297DA02B8F4BA8E0;
    localparam logic [255:0] ABCD16_DIGEST = 256'hDEBE9FF92275B8A138604889C18E5A4D6FDB70E5387E5765293DCBA39C0C5732;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] chain_in = '0;
    logic         word_valid = 1'b0;
    logic [31:0]  w_in = '0;
    logic [31:0]  wp_in = '0;
    logic         word_ready;
    logic         done;
    logic [255:0] chain_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] msg [0:15];
    logic [31:0] wexp [0:67];

    always #2 clk = ~clk;

    hce_engine u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chain_in   (chain_in),
        .word_valid (word_valid),
        .w_in       (w_in),
        .wp_in      (wp_in),
        .word_ready (word_ready),
        .done       (done),
        .chain_out  (chain_out)
    );

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    task automatic expand_block();
        for (int j = 0; j < 16; j++) wexp[j] = msg[j];
        for (int j = 16; j < 68; j++) begin
            logic [31:0] x;
            x = wexp[j-16] ^ wexp[j-9] ^ rl(wexp[j-3], 15);
            wexp[j] = x ^ rl(x, 15) ^ rl(x, 23) ^ rl(wexp[j-13], 7) ^ wexp[j-6];
        end
    endtask

    // bench model of one compression, written from the requirements
    function automatic logic [255:0] model(input logic [255:0] cv);
        logic [31:0] a, b, c, d, e, f, g, h, t, a12, s1, s2, p, q, x1, x2;
        {a, b, c, d, e, f, g, h} = cv;
        for (int j = 0; j < 64; j++) begin
            t   = rl((j < 16) ? 32'h79CC4519 : 32'h7A879D8A, j % 32);
            a12 = rl(a, 12);
            s1  = rl(a12 + e + t, 7);
            s2  = s1 ^ a12;
            p   = (j < 16) ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c));
            q   = (j < 16) ? (e ^ f ^ g) : ((e & f) | (~e & g));
            x1  = p + d + s2 + (wexp[j] ^ wexp[j+4]);
            x2  = q + h + s1 + wexp[j];
            d = c; c = rl(b, 9); b = a; a = x1;
            h = g; g = rl(f, 19); f = e; e = x2 ^ rl(x2, 9) ^ rl(x2, 17);
        end
        return {a, b, c, d, e, f, g, h} ^ cv;
    endfunction

    // drives one block; gap adds stall cycles, poke pulses start mid-run
    task automatic run_block(input logic [255:0] cv, input bit gap, input bit poke, output logic [255:0] dig);
        int  idx;
        int  cyc;
        bit  early;
        bit  v;
        logic r;
        @(negedge clk);
        start = 1'b1; chain_in = cv;
        @(negedge clk);
        start = 1'b0; chain_in = ~cv;
        chk("R2", "word_ready after start", {255'd0, word_ready}, 256'd1);
        idx = 0; cyc = 0; early = 0;
        while (idx < 64 && cyc < 1000) begin
            v = !gap || ((cyc % 3) != 2);
            word_valid = v;
            w_in  = wexp[idx];
            wp_in = wexp[idx] ^ wexp[idx+4];
            start = poke && (idx == 20 || idx == 45);
            if (start) chain_in = {8{32'hA5A5_0F0F}};
            if (done) early = 1;
            r = word_ready;
            @(posedge clk);
            if (v && r) idx++;
            @(negedge clk);
            cyc++;
        end
        word_valid = 1'b0; start = 1'b0;
        chk("R3", "done raised before 64 words", {255'd0, early}, 256'd0);
        chk("R8", "done low in merge cycle", {255'd0, done}, 256'd0);
        chk("R8", "word_ready low in merge cycle", {255'd0, word_ready}, 256'd0);
        @(negedge clk);
        chk("R8", "done high after merge", {255'd0, done}, 256'd1);
        dig = chain_out;
        @(negedge clk);
        chk("R8", "done is one cycle", {255'd0, done}, 256'd0);
        repeat (3) @(negedge clk);
        chk("R8", "chain_out held", chain_out, dig);
    endtask

    task automatic load_abc();
        for (int i = 0; i < 16; i++) msg[i] = 32'h0;
        msg[0]  = 32'h61626380;
        msg[15] = 32'h00000018;
        expand_block();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {255'd0, done}, 256'd0);
        chk("R1", "chain_out in reset", chain_out, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "word_ready after reset", {255'd0, word_ready}, 256'd0);
        chk("R1", "chain_out after reset", chain_out, 256'd0);
    endtask

    task automatic t_abc();
        logic [255:0] d;
        load_abc();
        run_block(IV, 1'b0, 1'b0, d);
        chk("R10", "abc digest (R4 R5 R6 R7)", d, ABC_DIGEST);
        chk("R7", "model agrees with digest", model(IV), ABC_DIGEST);
    endtask

    task automatic t_two_block();
        logic [255:0] d1;
        logic [255:0] d2;
        for (int i = 0; i < 16; i++) msg[i] = 32'h61626364;
        expand_block();
        run_block(IV, 1'b0, 1'b0, d1);
        chk("R11", "first block vs model", d1, model(IV));
        for (int i = 0; i < 16; i++) msg[i] = 32'h0;
        msg[0]  = 32'h80000000;
        msg[15] = 32'h00000200;
        expand_block();
        run_block(d1, 1'b0, 1'b0, d2);
        chk("R11", "two-block digest", d2, ABCD16_DIGEST);
    endtask

    task automatic t_stall();
        logic [255:0] d;
        logic [255:0] cv;
        for (int i = 0; i < 16; i++) msg[i] = (32'h9E3779B9 * (i + 1)) ^ 32'h13579BDF;
        expand_block();
        cv = {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210,
              32'hF0E1D2C3, 32'hB4A59687, 32'h78695A4B, 32'h3C2D1E0F};
        run_block(cv, 1'b1, 1'b0, d);
        chk("R3", "stalled block vs model (R4 R5 R6)", d, model(cv));
    endtask

    task automatic t_busy_start();
        logic [255:0] d;
        load_abc();
        run_block(IV, 1'b1, 1'b1, d);
        chk("R9", "start while busy ignored", d, ABC_DIGEST);
    endtask

    initial begin
        t_reset();
        t_abc();
        t_two_block();
        t_stall();
        t_busy_start();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule